// File: doc/BRIEF.md
# Word Serializer with Loopback Steering

This block turns a stream of 10-bit pre-encoded words into a single serial bit stream. A word is written into a holding register on the word strobe. It is then moved into a shift register and sent one bit per bit tick, least significant bit first. The bit tick is a synchronous enable that runs at ten times the word rate. A free-running count of ten ticks marks the word boundary. On each boundary the next held word is loaded, so the stream has no gaps.

A loopback control picks where the serial stream goes. With loopback low, the stream drives the line output, and the receiver feed carries the external line input. With loopback high, the stream is sent to the receiver feed instead, and the line output is held at 0. When loopback is released, the line output stays at 0 until the next word boundary and then carries live data again. A partial word is never sent on the line.

Top module: `serlink_tx`

## Requirements
- R1: `word_in` is captured into the holding register on a clock edge where `word_wr` is high, and is kept unchanged while `word_wr` is low. If several writes land between two loads, the last one is the word that is sent.
- R2: The serial bit can change only on a clock edge where `bit_tick` is high. Without a tick, `line_out` and the looped-back bit keep their value.
- R3: A loaded word is sent as ten bits on ten consecutive ticks, bit 0 first and bit 9 last.
- R4: On the tick after the tenth bit of a word, the word in the holding register is loaded. A write on that same edge is kept for the following word. There is no idle bit between words.
- R5: While `rst_n` is low, the shift register and holding register are zero and `line_out` is 0. The first tick after reset loads the holding register.
- R6: While `lpbk_en` is high, `rx_feed` carries the serial bit, and `line_out` is 0 from the same cycle onward.
- R7: After `lpbk_en` falls, `line_out` stays 0 until the next word load. From that load on it carries the serial bit. While `lpbk_en` is low, `rx_feed` equals `line_rx`.
- R8: While `lpbk_en` is high, `line_rx` has no effect on `rx_feed` or on `line_out`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bit_tick | input | 1 | Bit-rate enable, ten per word |
| word_wr | input | 1 | Word-rate strobe that writes the holding register |
| word_in | input | 10 | Pre-encoded word, bit 0 sent first |
| lpbk_en | input | 1 | 1 = send serial stream to receiver feed and hold line at 0 |
| line_rx | input | 1 | External serial input from the line |
| line_out | output | 1 | Serial output to the line |
| rx_feed | output | 1 | Serial input to the receiver (looped stream or line input) |

## Verification
Walking-one words show whether bit order and position are correct, since a reversed or shifted order moves the single 1 to a different slot. Ticks on every cycle, compared with ticks spaced several cycles apart, separate shifting on the tick from shifting on the clock. Writes that land early, late, twice, or on the same edge as a load separate last-write-wins from a load that takes a newer or older word. A loopback window with the line input toggling, released in the middle of a word, shows the immediate freeze, the wait for the word boundary, and that the line input is ignored during loopback.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  parameter int unsigned SL_WORD_W = 10;

  function automatic int unsigned sl_cnt_w(input int unsigned w);
    return (w < 2) ? 1 : $clog2(w);
  endfunction
endpackage

// File: rtl/serlink_word_reg.sv
module serlink_word_reg #(
  parameter int unsigned WORD_W = serlink_pkg::SL_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_wr,
  input  logic [WORD_W-1:0] word_in,
  output logic [WORD_W-1:0] hold_q
);
  logic [WORD_W-1:0] hold_d;

  always_comb begin
    hold_d = hold_q;
    if (word_wr) hold_d = word_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= '0;
    else        hold_q <= hold_d;
  end

  AST_HOLD_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !word_wr |=> $stable(hold_q)); // R1
endmodule

// File: rtl/serlink_shifter.sv
module serlink_shifter #(
  parameter int unsigned WORD_W = serlink_pkg::SL_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic [WORD_W-1:0] hold_q,
  output logic              ser_bit,
  output logic              load_now
);
  localparam int unsigned CNT_W = serlink_pkg::sl_cnt_w(WORD_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  assign load_now = bit_tick && (cnt_q == LAST);
  assign ser_bit  = sh_q[0];

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    if (load_now) begin
      sh_d  = hold_q;
      cnt_d = '0;
    end else if (bit_tick) begin
      sh_d  = {1'b0, sh_q[WORD_W-1:1]};
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q  <= '0;
      cnt_q <= LAST;
    end else begin
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
    end
  end

  AST_BIT_STILL_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_tick |=> $stable(ser_bit)); // R2
  AST_SHIFT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_tick && !load_now) |=> (sh_q[0] == $past(sh_q[1]))); // R3
  AST_LOAD_TAKES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    load_now |=> (sh_q == $past(hold_q))); // R4
endmodule

// File: rtl/serlink_route.sv
module serlink_route (
  input  logic clk,
  input  logic rst_n,
  input  logic lpbk_en,
  input  logic load_now,
  input  logic ser_bit,
  input  logic line_rx,
  output logic line_out,
  output logic rx_feed
);
  logic live_q, live_d;

  always_comb begin
    live_d = live_q;
    if (lpbk_en)       live_d = 1'b0;
    else if (load_now) live_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) live_q <= 1'b1;
    else        live_q <= live_d;
  end

  assign line_out = live_q && !lpbk_en && ser_bit;
  assign rx_feed  = lpbk_en ? ser_bit : line_rx;

  AST_LIVE_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(live_q) |-> $past(load_now)); // R7
  AST_LINE_QUIET_AFTER_LOOP: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk_en && !load_now) |=> !line_out); // R6
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx #(
  parameter int unsigned WORD_W = serlink_pkg::SL_WORD_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              word_wr,
  input  logic [WORD_W-1:0] word_in,
  input  logic              lpbk_en,
  input  logic              line_rx,
  output logic              line_out,
  output logic              rx_feed
);
  logic [WORD_W-1:0] hold_q;
  logic              ser_bit;
  logic              load_now;

  serlink_word_reg #(.WORD_W(WORD_W)) u_word (
    .clk(clk), .rst_n(rst_n), .word_wr(word_wr), .word_in(word_in), .hold_q(hold_q)
  );

  serlink_shifter #(.WORD_W(WORD_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .hold_q(hold_q),
    .ser_bit(ser_bit), .load_now(load_now)
  );

  serlink_route u_route (
    .clk(clk), .rst_n(rst_n), .lpbk_en(lpbk_en), .load_now(load_now),
    .ser_bit(ser_bit), .line_rx(line_rx), .line_out(line_out), .rx_feed(rx_feed)
  );

  AST_FEED_IGNORES_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    (lpbk_en && $past(lpbk_en) && !$past(bit_tick)) |-> $stable(rx_feed)); // R8
endmodule

// File: tb/serlink_tx_tb_top.sv
module serlink_tx_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       bit_tick, word_wr, lpbk_en, line_rx;
  logic [9:0] word_in;
  logic       line_out, rx_feed;

  always #2.5 clk = ~clk;

  serlink_tx #(.WORD_W(10)) dut_i (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .word_wr(word_wr),
    .word_in(word_in), .lpbk_en(lpbk_en), .line_rx(line_rx),
    .line_out(line_out), .rx_feed(rx_feed)
  );

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 0;

  // behavioural reference: a word being sent and the index of the current bit
  logic [9:0] m_hold, m_cur;
  int         m_idx;
  bit         m_live;
  logic [9:0] wq[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hold = '0; m_cur = '0; m_idx = 9; m_live = 1;
    end else begin
      if (bit_tick) begin
        if (m_idx == 9) begin
          m_cur = m_hold; m_idx = 0;
          if (wq.size() > 0) void'(wq.pop_front());
          if (!lpbk_en) m_live = 1;
        end else m_idx++;
      end
      if (lpbk_en) m_live = 0;
      if (word_wr) begin m_hold = word_in; wq.push_back(word_in); end
    end
  end

  task automatic compare(input string tag);
    logic b, exp_line, exp_feed;
    b = m_cur[m_idx];
    exp_line = (rst_n && m_live && !lpbk_en) ? b : 1'b0;
    exp_feed = lpbk_en ? b : line_rx;
    if (!rst_n) exp_line = 1'b0;
    n_cmp++;
    if (line_out !== exp_line || rx_feed !== exp_feed) begin
      n_bad++;
      $display("FAIL %s: line_out=%b rx_feed=%b expected line_out=%b rx_feed=%b t=%0t",
               tag, line_out, rx_feed, exp_line, exp_feed, $time);
    end
  endtask

  task automatic step(input logic be, input logic we, input logic [9:0] w,
                      input logic lp, input logic rx, input string tag);
    bit_tick = be; word_wr = we; word_in = w; lpbk_en = lp; line_rx = rx;
    @(negedge clk);
    compare(tag);
  endtask

  function automatic logic [9:0] pat(input int mode, input int k);
    case (mode)
      0: pat = 10'(1 << (k % 10));
      1: pat = (k[0]) ? 10'h2AA : 10'h155;
      default: pat = 10'((k * 37) ^ 10'h1C7);
    endcase
  endfunction

  // gap: ticks every gap cycles; write word when the bit index hits wr_at
  task automatic run(input int cycles, input int gap, input int mode,
                     input int wr_at, input logic lp, input string tag);
    int k = 0;
    for (int c = 0; c < cycles; c++) begin
      logic be, we;
      be = ((c % gap) == 0);
      we = be && (m_idx == wr_at);
      step(be, we, pat(mode, k), lp, c[1] ^ c[0], tag);
      if (we) k++;
    end
  endtask

  initial begin
    int wd = 0;
    while (!done) begin
      @(posedge clk);
      wd++;
      if (wd > 100000) begin
        n_bad++;
        $display("FAIL watchdog: run did not finish, expected end before 100000 cycles");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    bit_tick = 0; word_wr = 0; word_in = '0; lpbk_en = 0; line_rx = 0;
    @(negedge clk);
    // R5: outputs under reset, line input passes to receiver feed
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 10'h3FF, 1'b0, i[0], "R5 reset");
    rst_n = 1'b1;
    // R5: first tick loads the (zero) holding register
    step(1'b1, 1'b0, 10'h3FF, 1'b0, 1'b1, "R5 first load");
    for (int i = 0; i < 10; i++) step(1'b1, 1'b0, 10'h000, 1'b0, 1'b0, "R5 zero word");
    // R3: walking one, tick every cycle
    run(120, 1, 0, 4, 1'b0, "R3 walking one");
    // R4: alternating words, written on the load edge itself
    run(80, 1, 1, 9, 1'b0, "R4 write on load edge");
    // R2: sparse ticks
    run(150, 3, 2, 6, 1'b0, "R2 sparse tick");
    // R1: two writes before a load, last one wins
    while (m_idx != 2) step(1'b1, 1'b0, '0, 1'b0, 1'b0, "R1 align");
    step(1'b1, 1'b1, 10'h0F0, 1'b0, 1'b0, "R1 first write");
    step(1'b1, 1'b1, 10'h30C, 1'b0, 1'b0, "R1 second write");
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 10'h3FF, 1'b0, 1'b0, "R1 last write wins");
    // R6 and R8: loopback with a toggling line input
    run(60, 1, 2, 5, 1'b1, "R6 loopback");
    for (int i = 0; i < 12; i++) step(1'b0, 1'b0, '0, 1'b1, i[0], "R8 line ignored");
    // R7: release mid-word, line waits for the boundary
    while (m_idx != 3) step(1'b1, 1'b0, '0, 1'b1, 1'b0, "R7 align");
    run(60, 1, 0, 5, 1'b0, "R7 release");
    run(40, 2, 1, 7, 1'b0, "R7 release sparse");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule